// File: doc/BRIEF.md
# Multi-Lane Serial Flash Slave Front-End

This block is the pin-side front end of a serial flash slave. It watches the chip-select, the serial clock and four data pins, collects the 8-bit command code and the 24-bit address, and hands both to the rest of the device as single-cycle strobes. For program commands it also collects the data bytes. For read commands it drives data back from a behavioural memory stub. It controls one output enable per data pin. The number of pins used in each phase depends on the selected bus protocol and on the command code.

Three protocols exist. The extended protocol sends the command on one pin, and certain commands widen the address and data phases to two or four pins. The dual protocol and the quad protocol use two or four pins in every phase. When a program or erase runs from the high-voltage supply, a quad selection falls back to the extended protocol, and quad returns once that supply drops. The block also reports when the device may sit in standby. It ignores all bus activity after reset until it has seen a first falling edge of chip-select.

The serial pins are oversampled by the system clock `clk`. The bus inputs are assumed to arrive already synchronised to that clock.

Top module: `sfe_top`

## Requirements
- R1: On each serial-clock rising edge, the block shifts in 1, 2 or 4 bits, most significant first. A single lane is dq_in[0], two lanes are dq_in[1:0] with bit 1 carrying the higher bit, and four lanes are dq_in[3:0]. The 8-bit command and the 24-bit address are each presented with a one-cycle strobe (op_valid, addr_valid) in the clock after the rising edge that completes them.
- R2: One clock after chip-select is seen high, every dq_oe bit is 0 and dq_out is 0.
- R3: After reset, the block ignores serial-clock activity until chip-select has fallen at least once. A chip-select that is already low when reset ends does not count as a fall.
- R4: standby is 1 one clock after chip-select is high while array_busy is 0. It is 0 one clock after chip-select is low.
- R5: While array_busy is 1, standby is 0 from the next clock on, even with chip-select high.
- R6: In the extended protocol the command always uses one lane. The address uses two lanes for code 0xBB, four lanes for 0xEB, and one lane otherwise. The data phase uses two lanes for 0x3B, 0xBB and 0xA2, four lanes for 0x6B, 0xEB and 0x32, and one lane otherwise.
- R7: mode_sel encodes the protocol as 0 extended, 1 dual and 2 quad. In dual, every phase uses two lanes. In quad, every phase uses four lanes.
- R8: The protocol is latched at the falling edge of chip-select. If mode_sel is quad and hv_supply is 1, the extended protocol is latched instead.
- R9: Read data changes only in the clock after a serial-clock falling edge. The first chunk is driven on the first falling edge of the data phase. dq_oe is 0010 for one lane with the bit on dq_out[1], 0011 for two lanes, and 1111 for four lanes. Both lane groups carry the more significant bits on the higher pin.
- R10: Codes 0x0B, 0x3B, 0x6B, 0xBB and 0xEB insert DUMMY_CLKS serial clocks after the address, during which all dq_oe bits stay 0. Code 0x03 reads without dummy clocks.
- R11: The read stub returns byte address[7:0] XOR 0x5A. The address advances by one for each byte sent.
- R12: Codes 0x02, 0xA2 and 0x32 take data bytes after the address. Each completed byte appears on wr_data with a one-cycle wr_valid strobe.
- R13: Chip-select going high part way through a command discards it. The next selection starts again at the command phase.
- R14: Codes with no address (any code other than the reads, the programs and 0xD8) produce only op_valid. All later clocks in that selection are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip-select, active low |
| sck | input | 1 | Serial clock |
| dq_in | input | 4 | Data pin input levels |
| mode_sel | input | 2 | Protocol select: 0 extended, 1 dual, 2 quad |
| hv_supply | input | 1 | High-voltage program/erase supply is active |
| array_busy | input | 1 | Internal program, erase or status write is running |
| dq_out | output | 4 | Data pin output levels |
| dq_oe | output | 4 | Per-pin output enable |
| op_code | output | 8 | Last received command code |
| op_valid | output | 1 | One-cycle strobe for a new command code |
| addr | output | ADDR_BITS | Received address |
| addr_valid | output | 1 | One-cycle strobe for a new address |
| wr_data | output | 8 | Received program byte |
| wr_valid | output | 1 | One-cycle strobe for a new program byte |
| standby | output | 1 | Standby power state may be entered |

## Verification
A corrupted lane count or bit counter cannot stay hidden for long. The command strobe comes on the wrong rising edge and carries the wrong code, and every later address or data byte is misaligned by the time the next strobe fires. An error in the phase state shows up on the pins within one serial-clock fall. Examples are an enable during dummy clocks, enables on the wrong pins, or read data one chunk early or late. The bench compares pins, enables and standby in every clock, so such an error is caught in the clock where it first appears. A wrong latched protocol or a missed power-up gate shows up at the first command strobe of that selection.

// File: rtl/sfe_pkg.sv
package sfe_pkg;

    typedef enum logic [1:0] {
        PROTO_EXT  = 2'd0,
        PROTO_DUAL = 2'd1,
        PROTO_QUAD = 2'd2
    } proto_e;

    typedef enum logic [2:0] {
        PH_OPC    = 3'd0,
        PH_ADDR   = 3'd1,
        PH_DUMMY  = 3'd2,
        PH_RDATA  = 3'd3,
        PH_WDATA  = 3'd4,
        PH_IGNORE = 3'd5
    } phase_e;

    // log2 of the lane count: 0 -> 1 lane, 1 -> 2 lanes, 2 -> 4 lanes
    typedef logic [1:0] lanes_t;

    function automatic logic op_is_read(input logic [7:0] op);
        return (op == 8'h03) || (op == 8'h0B) || (op == 8'h3B) ||
               (op == 8'h6B) || (op == 8'hBB) || (op == 8'hEB);
    endfunction

    function automatic logic op_is_prog(input logic [7:0] op);
        return (op == 8'h02) || (op == 8'hA2) || (op == 8'h32);
    endfunction

    function automatic logic op_has_addr(input logic [7:0] op);
        return op_is_read(op) || op_is_prog(op) || (op == 8'hD8);
    endfunction

    function automatic logic op_has_dummy(input logic [7:0] op);
        return op_is_read(op) && (op != 8'h03);
    endfunction

    function automatic lanes_t lanes_for(input proto_e p, input phase_e ph,
                                         input logic [7:0] op);
        lanes_t l;
        l = 2'd0;
        if (p == PROTO_DUAL) begin
            l = 2'd1;
        end else if (p == PROTO_QUAD) begin
            l = 2'd2;
        end else if (ph == PH_ADDR) begin
            if (op == 8'hBB)      l = 2'd1;
            else if (op == 8'hEB) l = 2'd2;
        end else if (ph == PH_RDATA || ph == PH_WDATA) begin
            if (op == 8'h3B || op == 8'hBB || op == 8'hA2)      l = 2'd1;
            else if (op == 8'h6B || op == 8'hEB || op == 8'h32) l = 2'd2;
        end
        return l;
    endfunction

    function automatic logic [3:0] oe_mask(input lanes_t l);
        case (l)
            2'd0:    return 4'b0010;
            2'd1:    return 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

endpackage

// File: rtl/sfe_edges.sv
module sfe_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_fall,
    output logic armed
);

    typedef struct packed {
        logic sck;
        logic cs;
        logic armed;
    } edge_st_t;

    edge_st_t q, d;

    always_comb begin
        d       = q;
        d.sck   = sck;
        d.cs    = cs_n;
        d.armed = q.armed | (~cs_n & q.cs);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sck_rise = sck & ~q.sck;
    assign sck_fall = ~sck & q.sck;
    assign cs_fall  = ~cs_n & q.cs;
    assign armed    = q.armed;

endmodule

// File: rtl/sfe_lanes.sv
module sfe_lanes
    import sfe_pkg::*;
(
    input  lanes_t     lanes,
    input  logic [3:0] dq_in,
    input  logic [3:0] top_nib,
    output logic [3:0] in_bits,
    output logic [3:0] pins_out
);

    always_comb begin
        case (lanes)
            2'd0: begin
                in_bits  = {3'b000, dq_in[0]};
                pins_out = {2'b00, top_nib[3], 1'b0};
            end
            2'd1: begin
                in_bits  = {2'b00, dq_in[1:0]};
                pins_out = {2'b00, top_nib[3:2]};
            end
            default: begin
                in_bits  = dq_in;
                pins_out = top_nib;
            end
        endcase
    end

endmodule

// File: rtl/sfe_read_stub.sv
module sfe_read_stub #(
    parameter logic [7:0] SCRAMBLE = 8'h5A
) (
    input  logic [7:0] addr_lo,
    output logic [7:0] rd_byte
);

    assign rd_byte = addr_lo ^ SCRAMBLE;

endmodule

// File: rtl/sfe_top.sv
module sfe_top
    import sfe_pkg::*;
#(
    parameter int ADDR_BITS  = 24,
    parameter int DUMMY_CLKS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_n,
    input  logic                 sck,
    input  logic [3:0]           dq_in,
    input  logic [1:0]           mode_sel,
    input  logic                 hv_supply,
    input  logic                 array_busy,
    output logic [3:0]           dq_out,
    output logic [3:0]           dq_oe,
    output logic [7:0]           op_code,
    output logic                 op_valid,
    output logic [ADDR_BITS-1:0] addr,
    output logic                 addr_valid,
    output logic [7:0]           wr_data,
    output logic                 wr_valid,
    output logic                 standby
);

    localparam int CNT_W  = $clog2(ADDR_BITS + 1);
    localparam int DCNT_W = $clog2(DUMMY_CLKS + 2);

    typedef struct packed {
        phase_e               phase;
        proto_e               proto;
        logic [7:0]           op;
        logic [ADDR_BITS-1:0] acc;
        logic [CNT_W-1:0]     cnt;
        logic [DCNT_W-1:0]    dcnt;
        logic [ADDR_BITS-1:0] rd_addr;
        logic [7:0]           sh_out;
        logic [3:0]           out_left;
        logic [3:0]           dq_out;
        logic [3:0]           dq_oe;
        logic [ADDR_BITS-1:0] addr;
        logic                 op_valid;
        logic                 addr_valid;
        logic [7:0]           wr_data;
        logic                 wr_valid;
        logic                 standby;
    } fe_st_t;

    fe_st_t q, d;

    logic                 sck_rise, sck_fall, cs_fall, armed;
    lanes_t               ln;
    logic [2:0]           stepb;
    logic [3:0]           in_bits, pins_out;
    logic [7:0]           stub_byte, byte_sel;
    logic [ADDR_BITS-1:0] acc_sh;
    logic [CNT_W-1:0]     cnt_n;
    logic [DCNT_W-1:0]    dcnt_n;
    logic [3:0]           left_base;
    proto_e               eff_proto;

    sfe_edges i_edges (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck      (sck),
        .cs_n     (cs_n),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .cs_fall  (cs_fall),
        .armed    (armed)
    );

    sfe_lanes i_lanes (
        .lanes    (ln),
        .dq_in    (dq_in),
        .top_nib  (byte_sel[7:4]),
        .in_bits  (in_bits),
        .pins_out (pins_out)
    );

    sfe_read_stub i_stub (
        .addr_lo (q.rd_addr[7:0]),
        .rd_byte (stub_byte)
    );

    // Quad selection drops to the extended protocol while the high-voltage supply is on
    assign eff_proto = (mode_sel == 2'd2) ? (hv_supply ? PROTO_EXT : PROTO_QUAD) :
                       (mode_sel == 2'd1) ? PROTO_DUAL : PROTO_EXT;

    assign ln        = lanes_for(q.proto, q.phase, q.op);
    assign stepb     = 3'd1 << ln;
    assign acc_sh    = (q.acc << stepb) | ADDR_BITS'(in_bits);
    assign cnt_n     = q.cnt + CNT_W'(stepb);
    assign dcnt_n    = q.dcnt + 1'b1;
    assign byte_sel  = (q.out_left == 4'd0) ? stub_byte : q.sh_out;
    assign left_base = (q.out_left == 4'd0) ? 4'd8 : q.out_left;

    always_comb begin
        d            = q;
        d.op_valid   = 1'b0;
        d.addr_valid = 1'b0;
        d.wr_valid   = 1'b0;
        d.standby    = cs_n & ~array_busy;

        if (cs_n) begin
            d.phase    = PH_OPC;
            d.cnt      = '0;
            d.acc      = '0;
            d.dcnt     = '0;
            d.out_left = '0;
            d.dq_oe    = '0;
            d.dq_out   = '0;
        end else if (cs_fall) begin
            d.proto = eff_proto;
        end else if (armed) begin
            if (sck_rise) begin
                d.acc = acc_sh;
                d.cnt = cnt_n;
                case (q.phase)
                    PH_OPC: if (cnt_n == CNT_W'(8)) begin
                        d.op       = acc_sh[7:0];
                        d.op_valid = 1'b1;
                        d.cnt      = '0;
                        d.phase    = op_has_addr(acc_sh[7:0]) ? PH_ADDR : PH_IGNORE;
                    end
                    PH_ADDR: if (cnt_n == CNT_W'(ADDR_BITS)) begin
                        d.addr       = acc_sh;
                        d.rd_addr    = acc_sh;
                        d.addr_valid = 1'b1;
                        d.cnt        = '0;
                        if (op_is_read(q.op))
                            d.phase = (op_has_dummy(q.op) && DUMMY_CLKS != 0) ? PH_DUMMY : PH_RDATA;
                        else if (op_is_prog(q.op))
                            d.phase = PH_WDATA;
                        else
                            d.phase = PH_IGNORE;
                    end
                    PH_DUMMY: begin
                        d.dcnt = dcnt_n;
                        if (dcnt_n == DCNT_W'(DUMMY_CLKS)) begin
                            d.dcnt  = '0;
                            d.phase = PH_RDATA;
                        end
                    end
                    PH_WDATA: if (cnt_n == CNT_W'(8)) begin
                        d.wr_data  = acc_sh[7:0];
                        d.wr_valid = 1'b1;
                        d.cnt      = '0;
                    end
                    default: ;
                endcase
            end
            if (sck_fall && q.phase == PH_RDATA) begin
                if (q.out_left == 4'd0) d.rd_addr = q.rd_addr + 1'b1;
                d.dq_out   = pins_out;
                d.dq_oe    = oe_mask(ln);
                d.sh_out   = byte_sel << stepb;
                d.out_left = left_base - {1'b0, stepb};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign dq_out     = q.dq_out;
    assign dq_oe      = q.dq_oe;
    assign op_code    = q.op;
    assign op_valid   = q.op_valid;
    assign addr       = q.addr;
    assign addr_valid = q.addr_valid;
    assign wr_data    = q.wr_data;
    assign wr_valid   = q.wr_valid;
    assign standby    = q.standby;

endmodule

// File: rtl/sfe_checks.sv
module sfe_checks (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       sck,
    input logic       array_busy,
    input logic [3:0] dq_oe,
    input logic       standby,
    input logic       op_valid,
    input logic       addr_valid,
    input logic       wr_valid
);

    p_oe_off_deselect_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (dq_oe == 4'b0000));

    p_standby_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && !array_busy) |=> standby);

    p_standby_active_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |=> !standby);

    p_standby_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        array_busy |=> !standby);

    p_oe_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe == 4'b0000) || (dq_oe == 4'b0010) ||
        (dq_oe == 4'b0011) || (dq_oe == 4'b1111));

    p_oe_after_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|dq_oe) |-> ($past(sck, 2) && !$past(sck)));

    p_strobe_after_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid || addr_valid || wr_valid) |-> ($past(sck) && !$past(sck, 2)));

    p_single_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({op_valid, addr_valid, wr_valid}));

endmodule

bind sfe_top sfe_checks i_sfe_checks (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .sck        (sck),
    .array_busy (array_busy),
    .dq_oe      (dq_oe),
    .standby    (standby),
    .op_valid   (op_valid),
    .addr_valid (addr_valid),
    .wr_valid   (wr_valid)
);

// File: tb/test_sfe_top.sv
module test_sfe_top;

    localparam int AB = 24;
    localparam int ND = 8;

    logic          clk = 1'b0;
    logic          rst_n, cs_n, sck, hv_supply, array_busy;
    logic [3:0]    dq_in;
    logic [1:0]    mode_sel;
    logic [3:0]    dq_out, dq_oe;
    logic [7:0]    op_code, wr_data;
    logic [AB-1:0] addr;
    logic          op_valid, addr_valid, wr_valid, standby;

    always #4 clk = ~clk;

    sfe_top #(.ADDR_BITS(AB), .DUMMY_CLKS(ND)) i_sfe_top (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .dq_in(dq_in),
        .mode_sel(mode_sel), .hv_supply(hv_supply), .array_busy(array_busy),
        .dq_out(dq_out), .dq_oe(dq_oe), .op_code(op_code), .op_valid(op_valid),
        .addr(addr), .addr_valid(addr_valid), .wr_data(wr_data),
        .wr_valid(wr_valid), .standby(standby)
    );

    int         n_chk = 0;
    int         n_err = 0;
    bit         done  = 0;
    string      cur   = "R3";
    logic [3:0] exp_out = 4'b0;
    logic [3:0] exp_oe  = 4'b0;
    logic       exp_sb  = 1'b0;
    logic [7:0]    q_op[$];
    logic [AB-1:0] q_ad[$];
    logic [7:0]    q_wr[$];
    logic [7:0]    rdq[$];

    task automatic chk(input bit ok, input string what, input logic [31:0] act,
                       input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", cur, what, act, expv);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(dq_oe === exp_oe, "dq_oe", 32'(dq_oe), 32'(exp_oe));
            chk(dq_out === exp_out, "dq_out", 32'(dq_out), 32'(exp_out));
            chk(standby === exp_sb, "standby", 32'(standby), 32'(exp_sb));
            if (op_valid) begin
                if (q_op.size() == 0) chk(0, "unexpected op strobe", 32'(op_code), 0);
                else begin
                    logic [7:0] e;
                    e = q_op.pop_front();
                    chk(op_code === e, "op_code", 32'(op_code), 32'(e));
                end
            end
            if (addr_valid) begin
                if (q_ad.size() == 0) chk(0, "unexpected addr strobe", 32'(addr), 0);
                else begin
                    logic [AB-1:0] e;
                    e = q_ad.pop_front();
                    chk(addr === e, "addr", 32'(addr), 32'(e));
                end
            end
            if (wr_valid) begin
                if (q_wr.size() == 0) chk(0, "unexpected write strobe", 32'(wr_data), 0);
                else begin
                    logic [7:0] e;
                    e = q_wr.pop_front();
                    chk(wr_data === e, "wr_data", 32'(wr_data), 32'(e));
                end
            end
        end
    endtask

    function automatic logic [3:0] lanemask(input int w);
        return 4'((1 << w) - 1);
    endfunction

    // rdq holds pairs: expected dq_out then expected dq_oe for the next fall
    task automatic sbit(input logic [3:0] din, input bit rd);
        dq_in = din;
        step(1);
        sck = 1'b1;
        step(1);
        sck = 1'b0;
        if (rd && rdq.size() >= 2) begin
            exp_out = 4'(rdq.pop_front());
            exp_oe  = 4'(rdq.pop_front());
        end
        step(1);
    endtask

    task automatic run_cmd(input string tag, input int ow, input logic [7:0] op,
                           input bit has_a, input int aw, input logic [AB-1:0] a,
                           input int nd, input int dw, input int nrd, input int nwr,
                           input int nx);
        rdq.delete();
        for (int k = 0; k <= nrd && nrd > 0; k++) begin
            logic [7:0] b;
            b = (a[7:0] + 8'(k)) ^ 8'h5A;           // R11 stub content
            for (int i = 8 - dw; i >= 0; i -= dw) begin
                logic [3:0] ch;
                ch = 4'((b >> i) & 8'(lanemask(dw)));
                rdq.push_back((dw == 1) ? {4'b0, 2'b00, ch[0], 1'b0} : {4'b0, ch});
                rdq.push_back((dw == 1) ? 8'h02 : (dw == 2) ? 8'h03 : 8'h0F);
            end
        end
        cur = tag;
        cs_n = 1'b0;
        exp_sb = 1'b0;
        step(1);
        for (int i = 8 - ow; i >= 0; i -= ow) begin
            if (i == 0) q_op.push_back(op);
            sbit(4'((op >> i) & 8'(lanemask(ow))), 1'b0);
        end
        if (has_a) begin
            for (int i = AB - aw; i >= 0; i -= aw) begin
                if (i == 0) q_ad.push_back(a);
                sbit(4'((a >> i) & AB'(lanemask(aw))), (i == 0) && nd == 0 && nrd > 0);
            end
        end
        for (int k = 0; k < nd; k++) sbit(4'hF, (k == nd - 1) && nrd > 0);
        for (int k = 0; k < nwr; k++) begin
            logic [7:0] b;
            b = 8'h3C + 8'(k * 29);
            for (int i = 8 - dw; i >= 0; i -= dw) begin
                if (i == 0) q_wr.push_back(b);
                sbit(4'((b >> i) & 8'(lanemask(dw))), 1'b0);
            end
        end
        for (int k = 0; k < nrd * 8 / dw; k++) sbit(4'h0, 1'b1);
        for (int k = 0; k < nx; k++) sbit(4'(k * 5), 1'b0);
        cur = "R2";
        cs_n = 1'b1;
        exp_oe = 4'b0;
        exp_out = 4'b0;
        exp_sb = ~array_busy;
        step(2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cs_n = 1'b0; sck = 1'b0; dq_in = 4'b0;
        mode_sel = 2'd0; hv_supply = 1'b0; array_busy = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R3: reset state and gating with chip-select low since reset
        cur = "R3";
        exp_sb = 1'b0;
        step(1);
        for (int i = 7; i >= 0; i--) sbit({3'b0, 1'(8'h06 >> i)}, 1'b0);
        for (int i = 0; i < 8; i++) sbit(4'h1, 1'b0);

        // R4: deselect without a busy cycle gives standby
        cur = "R4";
        cs_n = 1'b1;
        exp_sb = 1'b1;
        step(2);

        // R11: plain read, stub data across an address low-byte wrap
        run_cmd("R11", 1, 8'h03, 1, 1, 24'h0012FE, 0, 1, 3, 0, 0);
        // R10: fast read with dummy clocks held at high impedance
        run_cmd("R10", 1, 8'h0B, 1, 1, 24'h345670, ND, 1, 2, 0, 0);
        // R6: widened data phases in the extended protocol
        run_cmd("R6", 1, 8'h3B, 1, 1, 24'hABCDEF, ND, 2, 2, 0, 0);
        run_cmd("R6", 1, 8'h6B, 1, 1, 24'h000081, ND, 4, 2, 0, 0);
        run_cmd("R6", 1, 8'hBB, 1, 2, 24'h5A5A00, ND, 2, 1, 0, 0);
        // R9: four-lane address and data, output enables per lane count
        run_cmd("R9", 1, 8'hEB, 1, 4, 24'hC0FFEE, ND, 4, 3, 0, 0);
        // R12: program bytes in single and dual lane form
        run_cmd("R12", 1, 8'h02, 1, 1, 24'h100000, 0, 1, 0, 2, 0);
        run_cmd("R12", 1, 8'hA2, 1, 1, 24'h200001, 0, 2, 0, 3, 0);
        // R7: dual protocol and quad protocol
        mode_sel = 2'd1;
        run_cmd("R7", 2, 8'h0B, 1, 2, 24'h77AA55, ND, 2, 2, 0, 0);
        mode_sel = 2'd2;
        run_cmd("R7", 4, 8'h32, 1, 4, 24'h0F0F0F, 0, 4, 0, 2, 0);
        run_cmd("R7", 4, 8'h03, 1, 4, 24'h000010, 0, 4, 2, 0, 0);
        // R8: quad falls back to extended while the high-voltage supply is on
        hv_supply = 1'b1;
        run_cmd("R8", 1, 8'h6B, 1, 1, 24'h424242, ND, 4, 1, 0, 0);
        run_cmd("R8", 1, 8'hD8, 1, 1, 24'h030000, 0, 1, 0, 0, 0);
        hv_supply = 1'b0;
        mode_sel = 2'd0;

        // R13: abort part way through the address
        cur = "R13";
        cs_n = 1'b0;
        exp_sb = 1'b0;
        step(1);
        for (int i = 7; i >= 0; i--) begin
            if (i == 0) q_op.push_back(8'h03);
            sbit({3'b0, 1'(8'h03 >> i)}, 1'b0);
        end
        for (int i = 0; i < 9; i++) sbit(4'h1, 1'b0);
        cs_n = 1'b1;
        exp_sb = 1'b1;
        step(2);
        run_cmd("R13", 1, 8'h03, 1, 1, 24'h00A010, 0, 1, 1, 0, 0);

        // R14: command without address, trailing clocks ignored
        run_cmd("R14", 1, 8'h06, 0, 1, 24'h0, 0, 1, 0, 0, 16);

        // R5: busy cycle keeps standby off while deselected
        cur = "R5";
        array_busy = 1'b1;
        exp_sb = 1'b0;
        step(3);
        run_cmd("R5", 1, 8'h05, 0, 1, 24'h0, 0, 1, 0, 0, 0);
        cur = "R5";
        step(2);
        cur = "R4";
        array_busy = 1'b0;
        exp_sb = 1'b1;
        step(3);

        cur = "R1";
        chk(q_op.size() == 0, "pending op strobes", 32'(q_op.size()), 0);
        chk(q_ad.size() == 0, "pending addr strobes", 32'(q_ad.size()), 0);
        chk(q_wr.size() == 0, "pending write strobes", 32'(q_wr.size()), 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule